// File: doc/BRIEF.md
# Skewed Vector Module and Location Generator

This block turns a strided vector request into a stream of storage coordinates for a set of parallel memory modules. Element `i` of the vector goes to module `(d*i + C) mod M` and sits at row `base + floor(i / M)` inside that module. The caller supplies the first element index, the stride `d`, the offset `C`, the element count `N` and a row base. The block then returns one coordinate pair per accepted beat over a valid/ready output.

The module count `M` is a build parameter and may be any value of two or more, including a prime such as 17. When `M` is not a power of two, a short setup phase reduces the inputs modulo `M` by serial restoring division and forms `(d*s) mod M` by shift-and-add. No divider is built. During streaming each step adds `d mod M` to the current module number and subtracts `M` once when the sum overflows.

In the same setup phase an iterative gcd unit decides whether the request can be served without two elements landing in one module. It flags the access as conflict-free when `M >= N * gcd(M, d)`. For a matrix walk, the caller passes the stride of the direction being tested: the row stride, the column stride, or their sum or difference for the two diagonals.

Top module: `skew_addr_gen`

## Requirements
- R1: After reset, and whenever no request is in progress, `out_valid`, `busy` and `done` are 0.
- R2: The k-th accepted output beat of a request carries `out_module = (d*i + C) mod M`, where `i = s + k` and `s` is `start_idx`.
- R3: The same beat carries `out_loc = (loc_base + floor(i / M)) mod 2^LOC_W`. Between consecutive beats `out_loc` either stays the same or rises by exactly 1.
- R4: A request with count `N` yields exactly `N` accepted beats. `done` is then high for exactly one cycle, with `busy` low. A request with `N = 0` yields no beats and still raises `done`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_module`, `out_loc` and `out_index` hold their values into the next cycle.
- R6: In the cycle `done` is high, `conflict_free` equals 1 exactly when `M >= N * gcd(M, d)`, taking `gcd(M, 0) = M`.
- R7: Whenever `out_valid` is high, `out_module` is less than `M`.
- R8: A `start` pulse given while `busy` is high is ignored. The request in progress completes with its original parameters.
- R9: `out_index` carries `i` for every beat and rises by exactly 1 between consecutive beats of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request. Sampled only when idle |
| start_idx | input | IDX_W | First element index `s` |
| stride | input | IDX_W | Skew factor `d` |
| offset | input | IDX_W | Module offset `C` |
| count | input | IDX_W | Number of elements `N` |
| loc_base | input | LOC_W | Row added to every location |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | Beat holds a coordinate pair |
| out_module | output | MW | Module number of element `i` |
| out_loc | output | LOC_W | Row inside the module |
| out_index | output | IDX_W | Element index `i` of this beat |
| busy | output | 1 | A request is in setup or streaming |
| done | output | 1 | One-cycle pulse at the end of a request |
| conflict_free | output | 1 | Conflict-free verdict, meaningful with `done` |

## Verification
The properties assume that `start_idx + count` never passes `2^IDX_W`, so the element index does not wrap within a request. They also assume the consumer may stall at any beat. The stimulus keeps start indices below a few thousand and counts below fifty, which keeps every index far from the wrap. It drives `out_ready` from a random source so that stalls land on first, middle and last beats alike. A stray `start` is raised in the middle of a stream to show that the parameters latched at acceptance stay in force.

// File: rtl/skew_pkg.sv
package skew_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_MUL  = 2'd2,
      ST_RUN  = 2'd3
   } skew_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int mod_width(input int m);
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/skew_div.sv
module skew_div #(
   parameter int DW      = 16,
   parameter int MODULI  = 17,
   parameter int MW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] num,
   output logic [DW-1:0] quo,
   output logic [MW-1:0] rem,
   output logic          fin
);

   localparam logic [MW:0] MODV = (MW+1)'(MODULI);
   localparam int          CW   = $clog2(DW + 1);

   generate
      if (skew_pkg::is_pow2(MODULI)) begin : g_shift
         localparam int          LG   = $clog2(MODULI);
         localparam logic [DW-1:0] MASK = DW'(MODULI - 1);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               quo <= '0;
               rem <= '0;
               fin <= 1'b0;
            end else begin
               fin <= go;
               if (go) begin
                  quo <= num >> LG;
                  rem <= MW'(num & MASK);
               end
            end
         end
      end else begin : g_serial
         logic [DW-1:0] work;
         logic [CW-1:0] cnt;
         logic          act;
         logic [MW:0]   trial;
         logic          take;

         always_comb begin
            trial = {rem, work[DW-1]};
            take  = (trial >= MODV);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               work <= '0;
               cnt  <= '0;
               act  <= 1'b0;
               quo  <= '0;
               rem  <= '0;
               fin  <= 1'b0;
            end else begin
               fin <= 1'b0;
               if (go) begin
                  work <= num;
                  quo  <= '0;
                  rem  <= '0;
                  cnt  <= CW'(DW);
                  act  <= 1'b1;
               end else if (act) begin
                  work <= work << 1;
                  quo  <= {quo[DW-2:0], take};
                  rem  <= take ? MW'(trial - MODV) : MW'(trial);
                  cnt  <= cnt - 1'b1;
                  if (cnt == CW'(1)) begin
                     act <= 1'b0;
                     fin <= 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/skew_mulmod.sv
module skew_mulmod #(
   parameter int MODULI = 17,
   parameter int MW     = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [MW-1:0] a,
   input  logic [MW-1:0] b,
   output logic [MW-1:0] prod,
   output logic          fin
);

   localparam logic [MW:0] MODV = (MW+1)'(MODULI);
   localparam int          CW   = $clog2(MW + 1);

   logic [MW-1:0] bsh;
   logic [CW-1:0] cnt;
   logic          act;
   logic [MW:0]   dbl, red1, sum, nxt;

   always_comb begin
      dbl  = {prod, 1'b0};
      red1 = (dbl >= MODV) ? dbl - MODV : dbl;
      sum  = red1 + (bsh[MW-1] ? {1'b0, a} : '0);
      nxt  = (sum >= MODV) ? sum - MODV : sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bsh  <= '0;
         cnt  <= '0;
         act  <= 1'b0;
         prod <= '0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            bsh  <= b;
            prod <= '0;
            cnt  <= CW'(MW);
            act  <= 1'b1;
         end else if (act) begin
            bsh  <= bsh << 1;
            prod <= MW'(nxt);
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               act <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/skew_gcd.sv
module skew_gcd #(
   parameter int MW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [MW-1:0] x_in,
   input  logic [MW-1:0] y_in,
   output logic [MW-1:0] g,
   output logic          fin
);

   logic [MW-1:0] x, y;
   logic          act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x   <= '0;
         y   <= '0;
         g   <= '0;
         act <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            x   <= x_in;
            y   <= y_in;
            act <= 1'b1;
         end else if (act) begin
            if (y == '0) begin
               g   <= x;
               act <= 1'b0;
               fin <= 1'b1;
            end else if (x >= y) begin
               x <= x - y;
            end else begin
               x <= y;
               y <= x;
            end
         end
      end
   end

endmodule

// File: rtl/skew_stream.sv
module skew_stream #(
   parameter int IDX_W  = 16,
   parameter int LOC_W  = 16,
   parameter int MODULI = 17,
   parameter int MW     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MW-1:0]    mod0,
   input  logic [MW-1:0]    res0,
   input  logic [IDX_W-1:0] quo0,
   input  logic [IDX_W-1:0] idx0,
   input  logic [IDX_W-1:0] len,
   input  logic [MW-1:0]    stepm,
   input  logic [LOC_W-1:0] base,
   input  logic             ready,
   output logic             valid,
   output logic [MW-1:0]    module_o,
   output logic [LOC_W-1:0] loc_o,
   output logic [IDX_W-1:0] index_o,
   output logic             last
);

   localparam logic [MW:0]   MODV = (MW+1)'(MODULI);
   localparam logic [MW-1:0] TOP  = MW'(MODULI - 1);

   logic [MW-1:0]    res;
   logic [IDX_W-1:0] left;
   logic [MW:0]      msum;
   logic [MW-1:0]    mnext;
   logic             take;

   always_comb begin
      take  = valid && ready;
      last  = take && (left == IDX_W'(1));
      msum  = {1'b0, module_o} + {1'b0, stepm};
      mnext = (msum >= MODV) ? MW'(msum - MODV) : MW'(msum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         module_o <= '0;
         loc_o    <= '0;
         index_o  <= '0;
         res      <= '0;
         left     <= '0;
      end else if (load) begin
         valid    <= (len != '0);
         module_o <= mod0;
         loc_o    <= base + LOC_W'(quo0);
         index_o  <= idx0;
         res      <= res0;
         left     <= len;
      end else if (take) begin
         left     <= left - 1'b1;
         index_o  <= index_o + 1'b1;
         module_o <= mnext;
         if (left == IDX_W'(1)) begin
            valid <= 1'b0;
         end
         if (res == TOP) begin
            res   <= '0;
            loc_o <= loc_o + 1'b1;
         end else begin
            res <= res + 1'b1;
         end
      end
   end

endmodule

// File: rtl/skew_addr_gen.sv
module skew_addr_gen #(
   parameter int NUM_MODULES = 17,
   parameter int IDX_W       = 16,
   parameter int LOC_W       = 16,
   localparam int MW         = skew_pkg::mod_width(NUM_MODULES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] stride,
   input  logic [IDX_W-1:0] offset,
   input  logic [IDX_W-1:0] count,
   input  logic [LOC_W-1:0] loc_base,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [MW-1:0]    out_module,
   output logic [LOC_W-1:0] out_loc,
   output logic [IDX_W-1:0] out_index,
   output logic             busy,
   output logic             done,
   output logic             conflict_free
);
   import skew_pkg::*;

   localparam int          NDIV = 3;
   localparam int          PW   = IDX_W + MW;
   localparam logic [MW:0] MODV = (MW+1)'(NUM_MODULES);

   generate
      if (NUM_MODULES < 2) begin : g_bad_moduli
         $error("skew_addr_gen: NUM_MODULES must be at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("skew_addr_gen: IDX_W must be at least 2");
      end
      if (LOC_W < 1) begin : g_bad_loc
         $error("skew_addr_gen: LOC_W must be at least 1");
      end
   endgenerate

   skew_state_e      state;
   logic [IDX_W-1:0] s_r, d_r, c_r, n_r;
   logic [LOC_W-1:0] base_r;
   logic             div_go, mg_go, strm_load;
   logic [MW-1:0]    q0_lo_unused;
   logic [IDX_W-1:0] q0_r;
   logic [MW-1:0]    r0_r, dm_r, cm_r, mod0_r;
   logic             mul_seen, gcd_seen;

   logic [IDX_W-1:0] div_num [NDIV];
   logic [IDX_W-1:0] div_quo [NDIV];
   logic [MW-1:0]    div_rem [NDIV];
   logic [NDIV-1:0]  div_fin;

   logic [MW-1:0]    prod, g;
   logic             mul_fin, gcd_fin;
   logic             strm_last;
   logic             both_done;
   logic [MW:0]      m0_sum;
   logic [MW-1:0]    m0_red;
   logic [PW-1:0]    need;

   assign q0_lo_unused = '0;

   always_comb begin
      div_num[0] = s_r;
      div_num[1] = d_r;
      div_num[2] = c_r;
   end

   generate
      for (genvar k = 0; k < NDIV; k++) begin : g_div
         skew_div #(
            .DW     (IDX_W),
            .MODULI (NUM_MODULES),
            .MW     (MW)
         ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (div_go),
            .num   (div_num[k]),
            .quo   (div_quo[k]),
            .rem   (div_rem[k]),
            .fin   (div_fin[k])
         );
      end
   endgenerate

   skew_mulmod #(
      .MODULI (NUM_MODULES),
      .MW     (MW)
   ) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mg_go),
      .a     (dm_r),
      .b     (r0_r),
      .prod  (prod),
      .fin   (mul_fin)
   );

   skew_gcd #(
      .MW (MW)
   ) u_gcd (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mg_go),
      .x_in  (MW'(NUM_MODULES)),
      .y_in  (dm_r),
      .g     (g),
      .fin   (gcd_fin)
   );

   skew_stream #(
      .IDX_W  (IDX_W),
      .LOC_W  (LOC_W),
      .MODULI (NUM_MODULES),
      .MW     (MW)
   ) u_stream (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (strm_load),
      .mod0     (mod0_r),
      .res0     (r0_r),
      .quo0     (q0_r),
      .idx0     (s_r),
      .len      (n_r),
      .stepm    (dm_r),
      .base     (base_r),
      .ready    (out_ready),
      .valid    (out_valid),
      .module_o (out_module),
      .loc_o    (out_loc),
      .index_o  (out_index),
      .last     (strm_last)
   );

   always_comb begin
      both_done = (mul_seen || mul_fin) && (gcd_seen || gcd_fin);
      m0_sum    = {1'b0, prod} + {1'b0, cm_r};
      m0_red    = (m0_sum >= MODV) ? MW'(m0_sum - MODV) : MW'(m0_sum);
      need      = PW'(n_r) * PW'(g);
      busy      = (state != ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         s_r           <= '0;
         d_r           <= '0;
         c_r           <= '0;
         n_r           <= '0;
         base_r        <= '0;
         div_go        <= 1'b0;
         mg_go         <= 1'b0;
         strm_load     <= 1'b0;
         q0_r          <= '0;
         r0_r          <= '0;
         dm_r          <= '0;
         cm_r          <= '0;
         mod0_r        <= '0;
         mul_seen      <= 1'b0;
         gcd_seen      <= 1'b0;
         done          <= 1'b0;
         conflict_free <= 1'b0;
      end else begin
         div_go    <= 1'b0;
         mg_go     <= 1'b0;
         strm_load <= 1'b0;
         done      <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  s_r           <= start_idx;
                  d_r           <= stride;
                  c_r           <= offset;
                  n_r           <= count;
                  base_r        <= loc_base;
                  conflict_free <= 1'b0;
                  div_go        <= 1'b1;
                  state         <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (div_fin[0]) begin
                  q0_r     <= div_quo[0];
                  r0_r     <= div_rem[0];
                  dm_r     <= div_rem[1];
                  cm_r     <= div_rem[2];
                  mul_seen <= 1'b0;
                  gcd_seen <= 1'b0;
                  mg_go    <= 1'b1;
                  state    <= ST_MUL;
               end
            end
            ST_MUL: begin
               if (mul_fin) mul_seen <= 1'b1;
               if (gcd_fin) gcd_seen <= 1'b1;
               if (both_done && !mg_go) begin
                  mod0_r        <= m0_red;
                  conflict_free <= (need <= PW'(NUM_MODULES));
                  if (n_r == '0) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     strm_load <= 1'b1;
                     state     <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (strm_last) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/skew_addr_gen_chk.sv
module skew_addr_gen_chk #(
   parameter int NUM_MODULES = 17,
   parameter int IDX_W       = 16,
   parameter int LOC_W       = 16,
   parameter int MW          = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_ready,
   input logic             out_valid,
   input logic [MW-1:0]    out_module,
   input logic [LOC_W-1:0] out_loc,
   input logic [IDX_W-1:0] out_index,
   input logic             busy,
   input logic             done
);

   localparam logic [MW-1:0] MLIM = MW'(NUM_MODULES);

   // R1: nothing is offered while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);

   // R7: module number stays inside the module range
   p_mod_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_module < MLIM));

   // R5: stalled beat is held
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_module)
                                     && $stable(out_loc) && $stable(out_index)));

   // R4: done is a single-cycle pulse while idle
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !out_valid));

   // R9: index advances by one between beats
   p_index_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid && out_ready))
         |-> (out_index == $past(out_index) + 1'b1));

   // R3: row advances by zero or one between beats
   p_loc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid && out_ready))
         |-> ((out_loc == $past(out_loc)) || (out_loc == $past(out_loc) + 1'b1)));

endmodule

bind skew_addr_gen skew_addr_gen_chk #(
   .NUM_MODULES (NUM_MODULES),
   .IDX_W       (IDX_W),
   .LOC_W       (LOC_W),
   .MW          (MW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_ready  (out_ready),
   .out_valid  (out_valid),
   .out_module (out_module),
   .out_loc    (out_loc),
   .out_index  (out_index),
   .busy       (busy),
   .done       (done)
);

// File: tb/skew_addr_gen_tb.sv
module skew_addr_gen_tb;

   localparam int NM    = 17;
   localparam int IW    = 16;
   localparam int LW    = 16;
   localparam int MWB   = $clog2(NM + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IW-1:0] start_idx = '0, stride = '0, offset = '0, count = '0;
   logic [LW-1:0] loc_base = '0;
   logic          out_ready = 1'b0;
   logic          out_valid;
   logic [MWB-1:0] out_module;
   logic [LW-1:0] out_loc;
   logic [IW-1:0] out_index;
   logic          busy, done, conflict_free;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   skew_addr_gen #(.NUM_MODULES(NM), .IDX_W(IW), .LOC_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
      .stride(stride), .offset(offset), .count(count), .loc_base(loc_base),
      .out_ready(out_ready), .out_valid(out_valid), .out_module(out_module),
      .out_loc(out_loc), .out_index(out_index), .busy(busy), .done(done),
      .conflict_free(conflict_free));

   function automatic longint gcd_ref(input longint a, input longint b);
      longint x = a, y = b, t;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int mod_ref(input longint d, input longint c, input longint i);
      return int'((d * i + c) % NM);
   endfunction

   function automatic int loc_ref(input longint base, input longint i);
      return int'((base + i / NM) % (longint'(1) << LW));
   endfunction

   function automatic bit cf_ref(input longint n, input longint d);
      return longint'(NM) >= n * gcd_ref(NM, d % NM);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !ended) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         finish_run();
      end
   end

   // mode: 0 always ready, 1 random ready; inject raises a stray start mid stream
   task automatic run(input int s, input int d, input int c, input int n,
                      input int base, input int mode, input bit inject);
      int  got = 0;
      int  wait_cyc = 0;
      bit  seen_done = 1'b0;
      bit  pv = 1'b0, pr = 1'b0;
      int  pm = 0, pl = 0, pi = 0;
      bit  injected = 1'b0;
      @(negedge clk);
      start_idx = IW'(s); stride = IW'(d); offset = IW'(c);
      count = IW'(n); loc_base = LW'(base); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!seen_done && wait_cyc < 4000) begin
         if (inject && got == 2 && !injected) begin
            start = 1'b1;
            start_idx = 16'd999; stride = 16'd5; offset = 16'd7;
            count = 16'd3; loc_base = 16'd4000;
            injected = 1'b1;
         end else begin
            start = 1'b0;
         end
         out_ready = (mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
         #1;
         if (pv && !pr) begin
            check(out_valid && out_module == MWB'(pm) && out_loc == LW'(pl)
                  && out_index == IW'(pi), "R5 hold", out_module, pm);
         end
         if (done) begin
            seen_done = 1'b1;
            check(got == n, "R4 beat count", got, n);
            check(!busy, "R4 busy low at done", busy, 0);
            check(conflict_free == cf_ref(n, d), "R6 conflict flag",
                  conflict_free, cf_ref(n, d));
         end else if (out_valid && out_ready) begin
            longint i = longint'(s) + got;
            check(out_module == MWB'(mod_ref(d, c, i)),
                  inject ? "R8 R2 module" : "R2 module", out_module, mod_ref(d, c, i));
            check(out_loc == LW'(loc_ref(base, i)), "R3 location",
                  out_loc, loc_ref(base, i));
            check(out_index == IW'(i), "R9 index", out_index, i);
            check(out_module < MWB'(NM), "R7 range", out_module, NM - 1);
            got++;
         end
         pv = out_valid; pr = out_ready;
         pm = int'(out_module); pl = int'(out_loc); pi = int'(out_index);
         @(negedge clk);
         wait_cyc++;
      end
      start = 1'b0;
      if (!seen_done) check(1'b0, "R4 done never seen", got, n);
      #1;
      check(!out_valid && !busy && !done, "R1 idle after request", out_valid, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      #1;
      check(!out_valid && !busy && !done, "R1 reset state", {out_valid, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!out_valid && !busy && !done, "R1 after reset release",
            {out_valid, busy, done}, 0);

      run(0, 3, 2, 8, 0, 0, 1'b0);         // reference configuration
      run(0, 3, 2, 8, 0, 1, 1'b0);         // same with stalls
      run(5, 17, 4, 5, 10, 1, 1'b0);       // stride multiple of M: conflicts
      run(30, 34, 0, 1, 3, 1, 1'b0);       // gcd = M but one element
      run(2, 0, 16, 4, 0, 0, 1'b0);        // zero stride
      run(9, 7, 1, 0, 0, 0, 1'b0);         // empty request
      run(1000, 40000, 65535, 20, 100, 1, 1'b0);
      run(16, 1, 0, 40, 65530, 1, 1'b0);   // rows wrap over several modules
      run(3, 6, 9, 17, 0, 0, 1'b0);        // N = M, coprime stride
      run(3, 6, 9, 18, 0, 0, 1'b0);        // N = M + 1
      run(0, 2, 2, 12, 7, 1, 1'b1);        // stray start while busy
      for (int k = 0; k < 14; k++) begin
         run(int'($urandom_range(0, 3000)), int'($urandom_range(0, 65535)),
             int'($urandom_range(0, 65535)), int'($urandom_range(0, 45)),
             int'($urandom_range(0, 65535)), 1, 1'b0);
      end
      finish_run();
   end

endmodule